// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block is a bus master that erases an embedded NOR-style flash array through a simple request/acknowledge bus. A single start pulse brings in three things: an erase kind (one sector or the whole array), a sector base offset and a flash-type select. The sequencer then carries out the complete erase conversation with the flash interface and needs no further help from software.

An erase begins by switching the flash interface into 16-bit programming mode. The sequencer then writes the unlock preamble and the erase command, and polls the toggle status until the flash settles, reports a failure or runs out of time. A sector is erased in two passes, at its base and at base plus 4, and each pass has its own poll. Run mode is always restored at the end, on a failure as well as on success. A one-cycle done pulse then reports the result, with an error flag alongside it.

All waiting is measured in milliseconds. A prescaler with a parameterised number of clock cycles per millisecond sets the length of a millisecond. Small values make the timeouts reachable in a short run.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o and bus_req_o are all low, and no bus request is raised while the block is idle.
- R2: An accepted start first issues a 32-bit write (bus_wide_o=1) of value 1 to the mode register address MODE_REG_ADDR, then a 32-bit read of that same address. No 16-bit access comes before them.
- R3: The two unlock addresses depend on the type select. With ftype_i=0, the first address is 0x1550 and the second is 0x0AA8. With ftype_i=1, the first is 0x0AA8 and the second is 0x0554.
- R4: Each pass begins with six 16-bit writes in a fixed order: 0xAA to the first address, 0x55 to the second, 0x80 to the first, 0xAA to the first, 0x55 to the second, and last the command word.
- R5: With chip_i=0, the command word is 0x30. It is written first to the sector offset and, in a second pass, to the offset plus 4. With chip_i=1, the command word is 0x10, written to the first unlock address, and there is only one pass.
- R6: Each poll round makes three 16-bit reads of the poll address: a discarded read, then status A, then status B. The poll address is the pass's command address for a sector erase and the second unlock address for a chip erase. The pass succeeds when bit 6 of A equals bit 6 of B.
- R7: Suppose bit 6 of A and B differ and bit 5 of A is set. The block then makes two more reads, A' and B'. If bit 6 of A' equals bit 6 of B', the pass succeeds. Otherwise the erase fails.
- R8: Suppose bit 6 differs and bit 5 of A is clear. The block then waits one millisecond (CYC_PER_MS cycles) with no bus request and adds 1 to a millisecond count that each pass starts at zero. If the count exceeds SECT_TO_MS for a sector erase, or CHIP_TO_MS for a chip erase, the erase fails. Otherwise a new poll round begins. The wait makes the spacing between two bus requests exactly CYC_PER_MS cycles longer than usual.
- R9: Every erase ends with a 32-bit write of value 2 to MODE_REG_ADDR, then a 32-bit read of it, whether it succeeded or failed.
- R10: An error response on any access before the restore ends the erase at once. Run mode is restored and err_o is set.
- R11: done_o is high for exactly one cycle per erase. err_o holds the result from that cycle until the next accepted start.
- R12: A start pulse while busy_o is high has no effect on the bus traffic or the result.
- R13: Once raised, bus_req_o stays high with stable address, data, direction and width until bus_ack_i or bus_err_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| chip_i | input | 1 | 1 = whole-array erase, 0 = sector erase |
| ftype_i | input | 1 | Flash type select for unlock addresses |
| sect_off_i | input | AW | Sector base offset |
| busy_o | output | 1 | Erase in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Result of last erase (1 = failed) |
| bus_req_o | output | 1 | Bus request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_wide_o | output | 1 | 1 = 32-bit access, 0 = 16-bit |
| bus_addr_o | output | AW | Access address |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 16 | Read data, valid with bus_ack_i |
| bus_ack_i | input | 1 | Access completed |
| bus_err_i | input | 1 | Access completed with error |

## Verification
The bench builds the block with CYC_PER_MS=4, SECT_TO_MS=3 and CHIP_TO_MS=5. With these values the millisecond wait, and both timeout limits, are a few dozen cycles away. A responder models the flash toggle bit, with a configurable number of toggling reads and a settable bit-5 flag. With it, every poll outcome can be reached: settling at once, settling after a wait, recovery on the flag path, failure on the flag path, and expiry of the sector limit and of the chip limit. Error responses injected at chosen access numbers exercise the abort path.

// File: rtl/fes_pkg.sv
`timescale 1ns/1ps
package fes_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_MODE_W, S_MODE_R, S_UNLK, S_POLL, S_WAIT, S_RUN_W, S_RUN_R, S_DONE
  } fes_state_t;

  localparam logic [15:0] T1_FIRST  = 16'h1550;
  localparam logic [15:0] T1_SECOND = 16'h0AA8;
  localparam logic [15:0] T2_FIRST  = 16'h0AA8;
  localparam logic [15:0] T2_SECOND = 16'h0554;

  localparam logic [31:0] MODE_PROG = 32'h0000_0001;
  localparam logic [31:0] MODE_RUN  = 32'h0000_0002;

  localparam logic [15:0] CMD_SECTOR = 16'h0030;
  localparam logic [15:0] CMD_CHIP   = 16'h0010;

  localparam logic [15:0] TOGGLE_MASK = 16'h0040;
  localparam logic [15:0] TLIMIT_MASK = 16'h0020;

  localparam logic [2:0] LAST_STEP   = 3'd5;
  localparam int         PASS_STRIDE = 4;

  // poll round slots
  localparam logic [2:0] P_DUMMY = 3'd0;
  localparam logic [2:0] P_A     = 3'd1;
  localparam logic [2:0] P_B     = 3'd2;
  localparam logic [2:0] P_RA    = 3'd3;
  localparam logic [2:0] P_RB    = 3'd4;

  function automatic logic [15:0] first_addr(input logic type2);
    return type2 ? T2_FIRST : T1_FIRST;
  endfunction

  function automatic logic [15:0] second_addr(input logic type2);
    return type2 ? T2_SECOND : T1_SECOND;
  endfunction

  // preamble word for a given step; last step carries the erase command
  function automatic logic [15:0] unlock_word(input logic [2:0] step, input logic chip);
    case (step)
      3'd0, 3'd3: return 16'h00AA;
      3'd1, 3'd4: return 16'h0055;
      3'd2:       return 16'h0080;
      default:    return chip ? CMD_CHIP : CMD_SECTOR;
    endcase
  endfunction

  function automatic logic step_uses_second(input logic [2:0] step);
    return (step == 3'd1) || (step == 3'd4);
  endfunction

  function automatic logic toggle_settled(input logic [15:0] a, input logic [15:0] b);
    return ((a ^ b) & TOGGLE_MASK) == 16'h0000;
  endfunction

  function automatic logic tlimit_flag(input logic [15:0] a);
    return (a & TLIMIT_MASK) != 16'h0000;
  endfunction

endpackage

// File: rtl/fes_timer.sv
`timescale 1ns/1ps
module fes_timer #(
  parameter int CYC_PER_MS = 100000,
  parameter int SECT_TO_MS = 500,
  parameter int CHIP_TO_MS = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic go_i,
  input  logic chip_i,
  output logic wait_done_o,
  output logic expired_o
);
  localparam int MAX_LIM = (CHIP_TO_MS > SECT_TO_MS) ? CHIP_TO_MS : SECT_TO_MS;
  localparam int PW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam int MW = $clog2(MAX_LIM + 2);
  localparam logic [PW-1:0] PRE_LOAD = PW'(CYC_PER_MS - 1);
  localparam logic [MW-1:0] SECT_LIM = MW'(SECT_TO_MS);
  localparam logic [MW-1:0] CHIP_LIM = MW'(CHIP_TO_MS);

  logic [PW-1:0] pre_q;
  logic [MW-1:0] ms_q;
  logic          run_q;
  logic [MW-1:0] ms_next;

  assign ms_next     = ms_q + MW'(1);
  assign wait_done_o = run_q && (pre_q == '0);
  assign expired_o   = wait_done_o && (ms_next > (chip_i ? CHIP_LIM : SECT_LIM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
      run_q <= 1'b0;
    end else begin
      if (clr_i) ms_q <= '0;
      if (go_i) begin
        run_q <= 1'b1;
        pre_q <= PRE_LOAD;
      end else if (wait_done_o) begin
        run_q <= 1'b0;
        ms_q  <= ms_next;
      end else if (run_q) begin
        pre_q <= pre_q - PW'(1);
      end
    end
  end
endmodule

// File: rtl/fes_poll_eval.sv
`timescale 1ns/1ps
module fes_poll_eval import fes_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_i,
  input  logic [15:0] rdata_i,
  output logic        settled_o,
  output logic        tlimit_o
);
  logic [15:0] first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) first_q <= '0;
    else if (cap_i) first_q <= rdata_i;
  end

  assign settled_o = toggle_settled(first_q, rdata_i);
  assign tlimit_o  = tlimit_flag(first_q);
endmodule

// File: rtl/fes_ctrl.sv
`timescale 1ns/1ps
module fes_ctrl import fes_pkg::*; #(
  parameter int            AW        = 32,
  parameter logic [AW-1:0] MODE_ADDR = 32'h4000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          chip_i,
  input  logic          ftype_i,
  input  logic [AW-1:0] sect_off_i,
  input  logic          settled_i,
  input  logic          tlimit_i,
  input  logic          wait_done_i,
  input  logic          expired_i,
  input  logic          bus_ack_i,
  input  logic          bus_err_i,
  output logic          cap_o,
  output logic          tmr_clr_o,
  output logic          tmr_go_o,
  output logic          chip_o,
  output logic          fire_o,
  output logic          abort_o,
  output logic          waiting_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic          bus_wide_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [31:0]   bus_wdata_o
);
  fes_state_t    st_q, nx_st;
  logic [2:0]    step_q, nx_step;
  logic [2:0]    pidx_q, nx_pidx;
  logic          pass_q, nx_pass;
  logic          chip_q, ftype_q, err_q, req_q;
  logic [AW-1:0] off_q;
  logic          fire, abort, pass_end, in_bus;
  logic [AW-1:0] a_first, a_second, tgt, cmd_addr, poll_addr;

  assign fire      = req_q & (bus_ack_i | bus_err_i);
  assign a_first   = AW'(first_addr(ftype_q));
  assign a_second  = AW'(second_addr(ftype_q));
  assign tgt       = off_q + (pass_q ? AW'(PASS_STRIDE) : '0);
  assign cmd_addr  = chip_q ? a_first : tgt;
  assign poll_addr = chip_q ? a_second : tgt;
  assign in_bus    = (st_q == S_MODE_W) || (st_q == S_MODE_R) || (st_q == S_UNLK) ||
                     (st_q == S_POLL) || (st_q == S_RUN_W) || (st_q == S_RUN_R);

  // bus access fields derive from state only, so they hold while a request is open
  always_comb begin
    bus_we_o    = 1'b0;
    bus_wide_o  = 1'b0;
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    case (st_q)
      S_MODE_W: begin bus_we_o = 1'b1; bus_wide_o = 1'b1; bus_addr_o = MODE_ADDR; bus_wdata_o = MODE_PROG; end
      S_MODE_R: begin bus_wide_o = 1'b1; bus_addr_o = MODE_ADDR; end
      S_UNLK: begin
        bus_we_o    = 1'b1;
        bus_wdata_o = {16'h0000, unlock_word(step_q, chip_q)};
        if (step_q == LAST_STEP)           bus_addr_o = cmd_addr;
        else if (step_uses_second(step_q)) bus_addr_o = a_second;
        else                               bus_addr_o = a_first;
      end
      S_POLL:  bus_addr_o = poll_addr;
      S_RUN_W: begin bus_we_o = 1'b1; bus_wide_o = 1'b1; bus_addr_o = MODE_ADDR; bus_wdata_o = MODE_RUN; end
      S_RUN_R: begin bus_wide_o = 1'b1; bus_addr_o = MODE_ADDR; end
      default: ;
    endcase
  end

  always_comb begin
    nx_st    = st_q;
    nx_step  = step_q;
    nx_pidx  = pidx_q;
    nx_pass  = pass_q;
    abort    = 1'b0;
    pass_end = 1'b0;
    if (fire) begin
      case (st_q)
        S_MODE_W: nx_st = S_MODE_R;
        S_MODE_R: begin nx_st = S_UNLK; nx_step = '0; end
        S_UNLK: begin
          if (step_q == LAST_STEP) begin nx_st = S_POLL; nx_pidx = P_DUMMY; end
          else nx_step = step_q + 3'd1;
        end
        S_POLL: begin
          case (pidx_q)
            P_B: begin
              if (settled_i)     pass_end = 1'b1;
              else if (tlimit_i) nx_pidx = P_RA;
              else               nx_st = S_WAIT;
            end
            P_RB: begin
              if (settled_i) pass_end = 1'b1;
              else           abort = 1'b1;
            end
            default: nx_pidx = pidx_q + 3'd1;
          endcase
        end
        S_RUN_W: nx_st = S_RUN_R;
        S_RUN_R: nx_st = S_DONE;
        default: ;
      endcase
      if (bus_err_i && (st_q != S_RUN_W) && (st_q != S_RUN_R)) abort = 1'b1;
    end
    if ((st_q == S_WAIT) && wait_done_i) begin
      if (expired_i) abort = 1'b1;
      else begin nx_st = S_POLL; nx_pidx = P_DUMMY; end
    end
    if (pass_end) begin
      if (!chip_q && !pass_q) begin
        nx_pass = 1'b1;
        nx_st   = S_UNLK;
        nx_step = '0;
      end else begin
        nx_st = S_RUN_W;
      end
    end
    if (abort) nx_st = S_RUN_W;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      step_q  <= '0;
      pidx_q  <= '0;
      pass_q  <= 1'b0;
      chip_q  <= 1'b0;
      ftype_q <= 1'b0;
      off_q   <= '0;
      err_q   <= 1'b0;
      req_q   <= 1'b0;
    end else if (st_q == S_IDLE) begin
      if (start_i) begin
        st_q    <= S_MODE_W;
        chip_q  <= chip_i;
        ftype_q <= ftype_i;
        off_q   <= sect_off_i;
        err_q   <= 1'b0;
        step_q  <= '0;
        pidx_q  <= '0;
        pass_q  <= 1'b0;
      end
    end else if (st_q == S_DONE) begin
      st_q <= S_IDLE;
    end else begin
      if (fire) req_q <= 1'b0;
      else if (in_bus && !req_q) req_q <= 1'b1;
      st_q   <= nx_st;
      step_q <= nx_step;
      pidx_q <= nx_pidx;
      pass_q <= nx_pass;
      if (abort || (fire && bus_err_i)) err_q <= 1'b1;
    end
  end

  assign cap_o     = fire && (st_q == S_POLL) && ((pidx_q == P_A) || (pidx_q == P_RA));
  assign tmr_clr_o = fire && (st_q == S_UNLK) && (step_q == LAST_STEP);
  assign tmr_go_o  = fire && (st_q == S_POLL) && (pidx_q == P_B) && !settled_i && !tlimit_i;
  assign chip_o    = chip_q;
  assign fire_o    = fire;
  assign abort_o   = abort;
  assign waiting_o = (st_q == S_WAIT);
  assign busy_o    = (st_q != S_IDLE);
  assign done_o    = (st_q == S_DONE);
  assign err_o     = err_q;
  assign bus_req_o = req_q;
endmodule

// File: rtl/flash_erase_seq.sv
`timescale 1ns/1ps
module flash_erase_seq #(
  parameter int            AW            = 32,
  parameter int            CYC_PER_MS    = 100000,
  parameter int            SECT_TO_MS    = 500,
  parameter int            CHIP_TO_MS    = 20000,
  parameter logic [AW-1:0] MODE_REG_ADDR = 32'h4000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          chip_i,
  input  logic          ftype_i,
  input  logic [AW-1:0] sect_off_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic          bus_wide_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [31:0]   bus_wdata_o,
  input  logic [15:0]   bus_rdata_i,
  input  logic          bus_ack_i,
  input  logic          bus_err_i
);
  // named internal events, also watched by the checker
  logic ev_fire, ev_abort, ev_waiting;
  logic ev_cap, ev_settled, ev_tlimit;
  logic ev_tmr_clr, ev_tmr_go, ev_wait_done, ev_expired;
  logic chip_lat;

  fes_ctrl #(.AW(AW), .MODE_ADDR(MODE_REG_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_i), .chip_i(chip_i), .ftype_i(ftype_i), .sect_off_i(sect_off_i),
    .settled_i(ev_settled), .tlimit_i(ev_tlimit),
    .wait_done_i(ev_wait_done), .expired_i(ev_expired),
    .bus_ack_i(bus_ack_i), .bus_err_i(bus_err_i),
    .cap_o(ev_cap), .tmr_clr_o(ev_tmr_clr), .tmr_go_o(ev_tmr_go), .chip_o(chip_lat),
    .fire_o(ev_fire), .abort_o(ev_abort), .waiting_o(ev_waiting),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_wide_o(bus_wide_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o)
  );

  fes_poll_eval u_poll (
    .clk(clk), .rst_n(rst_n), .cap_i(ev_cap), .rdata_i(bus_rdata_i),
    .settled_o(ev_settled), .tlimit_o(ev_tlimit)
  );

  fes_timer #(.CYC_PER_MS(CYC_PER_MS), .SECT_TO_MS(SECT_TO_MS), .CHIP_TO_MS(CHIP_TO_MS)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(ev_tmr_clr), .go_i(ev_tmr_go), .chip_i(chip_lat),
    .wait_done_o(ev_wait_done), .expired_o(ev_expired)
  );
endmodule

// File: rtl/fes_chk.sv
`timescale 1ns/1ps
module fes_chk #(
  parameter int            AW        = 32,
  parameter logic [AW-1:0] MODE_ADDR = 32'h4000_0000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic          bus_wide_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [31:0]   bus_wdata_o,
  input logic          bus_ack_i,
  input logic          bus_err_i,
  input logic          ev_fire,
  input logic          ev_abort,
  input logic          ev_waiting
);
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !bus_req_o); // R1

  AST_WIDE_MODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && bus_wide_o |-> bus_addr_o == MODE_ADDR); // R2

  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_waiting |-> !bus_req_o); // R8

  AST_DONE_AFTER_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(ev_fire && !bus_we_o && bus_wide_o)); // R9

  AST_ABORT_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> ##1 (bus_req_o && bus_we_o && bus_wide_o && bus_wdata_o == 32'h2)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11

  AST_ERR_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !start_i |=> $stable(err_o)); // R11

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && !(bus_ack_i || bus_err_i) |=> bus_req_o && $stable(bus_addr_o) &&
      $stable(bus_wdata_o) && $stable(bus_we_o) && $stable(bus_wide_o)); // R13
endmodule

bind flash_erase_seq fes_chk #(.AW(AW), .MODE_ADDR(MODE_REG_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
  .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_wide_o(bus_wide_o),
  .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
  .bus_ack_i(bus_ack_i), .bus_err_i(bus_err_i),
  .ev_fire(ev_fire), .ev_abort(ev_abort), .ev_waiting(ev_waiting)
);

// File: tb/flash_erase_seq_tb.sv
`timescale 1ns/1ps
module flash_erase_seq_tb;
  localparam int AW  = 32;
  localparam int CPM = 4;
  localparam int STO = 3;
  localparam int CTO = 5;
  localparam logic [31:0] MREG = 32'h4000_0000;
  localparam int FOREVER_BUSY = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, chip_i = 1'b0, ftype_i = 1'b0;
  logic [AW-1:0] sect_off_i = '0;
  logic busy_o, done_o, err_o, bus_req_o, bus_we_o, bus_wide_o;
  logic [AW-1:0] bus_addr_o;
  logic [31:0] bus_wdata_o;
  logic [15:0] bus_rdata_i = '0;
  logic bus_ack_i = 1'b0, bus_err_i = 1'b0;

  always #2.5 clk = ~clk;

  flash_erase_seq #(.AW(AW), .CYC_PER_MS(CPM), .SECT_TO_MS(STO), .CHIP_TO_MS(CTO),
                    .MODE_REG_ADDR(MREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chip_i(chip_i), .ftype_i(ftype_i),
    .sect_off_i(sect_off_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_wide_o(bus_wide_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i),
    .bus_ack_i(bus_ack_i), .bus_err_i(bus_err_i));

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // flash responder model and access log
  int  cfg_busy = 0, busy_left = 0, err_at = -1, acc_idx = 0;
  bit  cfg_tflag = 0, tog = 0;
  int  log_n = 0;
  bit  log_we [64];
  bit  log_wide [64];
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];
  int  log_cyc [64];

  always @(posedge clk) begin
    if (rst_n && bus_req_o && !bus_ack_i && !bus_err_i) begin
      if (log_n < 64) begin
        log_we[log_n]   = bus_we_o;
        log_wide[log_n] = bus_wide_o;
        log_addr[log_n] = bus_addr_o;
        log_data[log_n] = bus_wdata_o;
        log_cyc[log_n]  = cyc;
      end
      log_n = log_n + 1;
      if (acc_idx == err_at) bus_err_i <= 1'b1;
      else                   bus_ack_i <= 1'b1;
      acc_idx = acc_idx + 1;
      if (!bus_we_o && !bus_wide_o) begin
        bus_rdata_i <= {9'b0, tog, cfg_tflag, 5'b0};
        if (busy_left > 0) begin tog = ~tog; busy_left = busy_left - 1; end
      end
      if (bus_we_o && !bus_wide_o && (bus_wdata_o == 32'h30 || bus_wdata_o == 32'h10))
        busy_left = cfg_busy;
    end else begin
      bus_ack_i <= 1'b0;
      bus_err_i <= 1'b0;
    end
  end

  // expected access list
  int  exp_n = 0;
  bit  exp_we [64];
  bit  exp_wide [64];
  logic [31:0] exp_addr [64];
  logic [31:0] exp_data [64];

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic push(input bit we, input bit wide, input logic [31:0] a, input logic [31:0] d);
    exp_we[exp_n] = we; exp_wide[exp_n] = wide; exp_addr[exp_n] = a; exp_data[exp_n] = d;
    exp_n++;
  endtask

  task automatic e_enter();
    push(1, 1, MREG, 32'h1);
    push(0, 1, MREG, 0);
  endtask

  task automatic e_leave();
    push(1, 1, MREG, 32'h2);
    push(0, 1, MREG, 0);
  endtask

  task automatic e_unlock(input logic [31:0] a1, input logic [31:0] a2, input logic [31:0] ca,
                          input logic [31:0] cmd);
    push(1, 0, a1, 32'hAA); push(1, 0, a2, 32'h55); push(1, 0, a1, 32'h80);
    push(1, 0, a1, 32'hAA); push(1, 0, a2, 32'h55); push(1, 0, ca, cmd);
  endtask

  task automatic e_reads(input logic [31:0] a, input int n);
    for (int i = 0; i < n; i++) push(0, 0, a, 0);
  endtask

  function automatic logic [31:0] fa1(input bit t2); return t2 ? 32'h0AA8 : 32'h1550; endfunction
  function automatic logic [31:0] fa2(input bit t2); return t2 ? 32'h0554 : 32'h0AA8; endfunction

  task automatic cmp_log(input string tag);
    int bad;
    chk(log_n == exp_n, {tag, " access count"}, log_n, exp_n);
    bad = -1;
    for (int i = 0; i < exp_n && i < log_n && i < 64; i++) begin
      if (bad < 0 && (log_we[i] != exp_we[i] || log_wide[i] != exp_wide[i] ||
          log_addr[i] != exp_addr[i] || (exp_we[i] && log_data[i] != exp_data[i])))
        bad = i;
    end
    if (bad >= 0)
      chk(0, {tag, " access content"}, {log_addr[bad], log_data[bad]}, {exp_addr[bad], exp_data[bad]});
    else
      chk(1, {tag, " access content"}, 0, 0);
  endtask

  // launch one erase, wait for done, check pulse width and result
  task automatic run_op(input bit chip, input bit t2, input logic [31:0] off, input int busy,
                        input bit tflag, input int eat, input bit mid, input bit exp_err,
                        input string tag);
    int w;
    cfg_busy = busy; cfg_tflag = tflag; err_at = eat; busy_left = 0; tog = 0;
    log_n = 0; acc_idx = 0;
    @(negedge clk);
    chip_i = chip; ftype_i = t2; sect_off_i = off; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; chip_i = ~chip; ftype_i = ~t2; sect_off_i = 32'h0000_7770;
    if (mid) begin
      repeat (20) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    w = 0;
    while (!done_o && w < 20000) begin @(negedge clk); w++; end
    chk(w < 20000, {tag, " watchdog (done reached)"}, w, 0);
    chk(err_o == exp_err, {tag, " err at done R11"}, err_o, exp_err);
    @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0, {tag, " done one cycle R11"}, done_o, 0);
    repeat (3) @(negedge clk);
    chk(err_o == exp_err, {tag, " err held after done R11"}, err_o, exp_err);
  endtask

  initial begin
    #(5.0 * 190000);
    n_err++; n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !err_o && !bus_req_o, "R1 reset state", {busy_o, done_o, err_o, bus_req_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!bus_req_o && !busy_o, "R1 idle no request", bus_req_o, 0);

    // R2 R3 R4 R5 R6 R9: type 1 sector erase, status settled at once
    exp_n = 0; e_enter();
    e_unlock(fa1(0), fa2(0), 32'h4000, 32'h30); e_reads(32'h4000, 3);
    e_unlock(fa1(0), fa2(0), 32'h4004, 32'h30); e_reads(32'h4004, 3);
    e_leave();
    run_op(0, 0, 32'h4000, 0, 0, -1, 0, 0, "R5 sector t1");
    cmp_log("R2 R3 R4 R5 R6 R9 sector t1");

    // R3 R5 R6: type 2 chip erase, one pass, poll at second address
    exp_n = 0; e_enter();
    e_unlock(fa1(1), fa2(1), fa1(1), 32'h10); e_reads(fa2(1), 3);
    e_leave();
    run_op(1, 1, 32'h0, 0, 0, -1, 0, 0, "R5 chip t2");
    cmp_log("R3 R5 R6 chip t2");

    // R3: type 1 chip erase and type 2 sector erase
    exp_n = 0; e_enter();
    e_unlock(fa1(0), fa2(0), fa1(0), 32'h10); e_reads(fa2(0), 3);
    e_leave();
    run_op(1, 0, 32'h0, 0, 0, -1, 0, 0, "R3 chip t1");
    cmp_log("R3 chip t1");
    exp_n = 0; e_enter();
    e_unlock(fa1(1), fa2(1), 32'h8000, 32'h30); e_reads(32'h8000, 3);
    e_unlock(fa1(1), fa2(1), 32'h8004, 32'h30); e_reads(32'h8004, 3);
    e_leave();
    run_op(0, 1, 32'h8000, 0, 0, -1, 0, 0, "R3 sector t2");
    cmp_log("R3 sector t2");

    // R8: four toggling reads -> one wait, then settled; two rounds per pass
    exp_n = 0; e_enter();
    e_unlock(fa1(0), fa2(0), 32'h20000, 32'h30); e_reads(32'h20000, 6);
    e_unlock(fa1(0), fa2(0), 32'h20004, 32'h30); e_reads(32'h20004, 6);
    e_leave();
    run_op(0, 0, 32'h20000, 4, 0, -1, 0, 0, "R8 one wait");
    cmp_log("R6 R8 one wait");
    chk((log_cyc[11] - log_cyc[10]) - (log_cyc[9] - log_cyc[8]) == CPM, "R8 wait length",
        (log_cyc[11] - log_cyc[10]) - (log_cyc[9] - log_cyc[8]), CPM);

    // R8: sector never settles -> STO+1 rounds then fail
    exp_n = 0; e_enter();
    e_unlock(fa1(0), fa2(0), 32'h100, 32'h30); e_reads(32'h100, 3 * (STO + 1));
    e_leave();
    run_op(0, 0, 32'h100, FOREVER_BUSY, 0, -1, 0, 1, "R8 sector timeout");
    cmp_log("R8 R9 sector timeout");

    // R8: chip never settles -> CTO+1 rounds then fail
    exp_n = 0; e_enter();
    e_unlock(fa1(1), fa2(1), fa1(1), 32'h10); e_reads(fa2(1), 3 * (CTO + 1));
    e_leave();
    run_op(1, 1, 32'h0, FOREVER_BUSY, 0, -1, 0, 1, "R8 chip timeout");
    cmp_log("R8 R9 chip timeout");

    // R7: flag set, still toggling on retry -> fail after five reads
    exp_n = 0; e_enter();
    e_unlock(fa1(0), fa2(0), 32'h40000, 32'h30); e_reads(32'h40000, 5);
    e_leave();
    run_op(0, 0, 32'h40000, FOREVER_BUSY, 1, -1, 0, 1, "R7 flag fail");
    cmp_log("R7 flag fail");

    // R7: flag set, settles on retry -> each pass succeeds with five reads
    exp_n = 0; e_enter();
    e_unlock(fa1(0), fa2(0), 32'h200, 32'h30); e_reads(32'h200, 5);
    e_unlock(fa1(0), fa2(0), 32'h204, 32'h30); e_reads(32'h204, 5);
    e_leave();
    run_op(0, 0, 32'h200, 3, 1, -1, 0, 0, "R7 flag recover");
    cmp_log("R7 flag recover");

    // R10: error response on third preamble write
    exp_n = 0; e_enter();
    push(1, 0, fa1(0), 32'hAA); push(1, 0, fa2(0), 32'h55); push(1, 0, fa1(0), 32'h80);
    e_leave();
    run_op(0, 0, 32'h300, 0, 0, 4, 0, 1, "R10 bus error unlock");
    cmp_log("R10 bus error unlock");

    // R10: error response on the very first access
    exp_n = 0; push(1, 1, MREG, 32'h1); e_leave();
    run_op(1, 0, 32'h0, 0, 0, 0, 0, 1, "R10 bus error mode");
    cmp_log("R10 bus error mode");

    // R11 R12: start pulse while busy changes nothing; err cleared by new start
    exp_n = 0; e_enter();
    e_unlock(fa1(0), fa2(0), 32'h4000, 32'h30); e_reads(32'h4000, 3);
    e_unlock(fa1(0), fa2(0), 32'h4004, 32'h30); e_reads(32'h4004, 3);
    e_leave();
    run_op(0, 0, 32'h4000, 0, 0, -1, 1, 0, "R12 start while busy");
    cmp_log("R12 start while busy");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule